// File: doc/BRIEF.md
# Locked-Atomic Split Detector and Lock Arbiter

This block sits next to a load/store unit and looks at every memory request before it goes on. A request carries an address, an operand size code, a locked-atomic flag and a cacheable flag. Plain loads and stores go through untouched. For a locked read-modify-write, the block works out whether the operand stays inside one 64-byte line or crosses into the next one. It then takes one of three actions:

- It grants a cheap cache-line lock.
- It raises a system bus lock and holds it until the memory side reports that both lines are done.
- If split detection is switched on, it turns the cross-line atomic into a precise alignment-check fault. In that case the request is never forwarded.

A small register port gives software two registers. A read-only capability word reports that detection is supported. A control word holds the detection enable, in bit 29 at register address 0x033. Requests use a valid/ready handshake. While a bus lock is held, no new request is taken.

Top module: `atomic_lock_arb`

## Requirements
- R1: A locked, cacheable request whose first and last byte are in the same 64-byte line produces, in the cycle after acceptance, a one-cycle `cache_lock` pulse and a one-cycle `fwd_valid` with `fwd_addr` equal to the request address. `bus_lock` and `fault_valid` stay low.
- R2: A request with `req_locked` low produces only a one-cycle `fwd_valid` in the cycle after acceptance. It gives no `cache_lock`, no `bus_lock` and no fault, whatever the address, size, cacheability or enable.
- R3: A locked split request with detection disabled gives `fwd_valid` for one cycle and sets `bus_lock` in the cycle after acceptance. `bus_lock` stays high until the cycle after `lock_done` is sampled high.
- R4: A locked request that fits in one line but has `req_cacheable` low gets a bus lock as in R3. It never faults, even with detection enabled.
- R5: A locked split request with detection enabled gives, in the cycle after acceptance, a one-cycle `fault_valid` with `fault_addr` equal to the request address. There is no `fwd_valid`, no `cache_lock` and no `bus_lock`.
- R6: The control register is at register address 0x033, and the detection enable is its bit 29. The enable resets to 0 and reads back where it was written. A request uses the enable value held before the cycle in which it is accepted, so a write in that same cycle does not affect it.
- R7: Writes to control bits other than bit 29 are ignored, and those bits read as 0.
- R8: Register address 0x0CF always reads 0x0000_0020: bit 5 is 1 and the other bits are 0. Writes to it have no effect. Every other register address reads 0.
- R9: A size code n from 0 to 4 means 2^n bytes. Codes 5 to 7 mean 16 bytes. The last byte is address + bytes − 1. The access is split when the last byte lies in a different line, which includes wrapping past the top of the address space.
- R10: `req_ready` is low exactly while `bus_lock` is high. A request is accepted only when `req_valid` and `req_ready` are both high. A request offered during a held lock produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 3 | Size code: 2^code bytes, saturating at 16 |
| req_locked | input | 1 | Request is a locked atomic |
| req_cacheable | input | 1 | Target memory is cacheable |
| fwd_valid | output | 1 | Request forwarded to memory (one cycle) |
| fwd_addr | output | 32 | Address of the forwarded request |
| cache_lock | output | 1 | Cache-line lock granted (one cycle) |
| bus_lock | output | 1 | System bus lock held |
| lock_done | input | 1 | Memory side finished the locked access |
| fault_valid | output | 1 | Alignment-check fault raised (one cycle) |
| fault_addr | output | 32 | Address of the faulting request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench tests operands that end exactly on a line's last byte against ones that spill one byte over, for every size, plus an address that wraps past the top of the space. A wrong last-byte calculation shows up there as a cache lock where a fault or bus lock was due, or the other way round. It then offers a request while a bus lock is held and releases the lock afterwards. An arbiter that drops the lock early, or takes requests during the hold, emits outputs for a request it should have stalled. The remaining checks are these:
- An uncacheable single-line atomic with detection enabled must get a bus lock and no fault.
- A control write in the same cycle as a split request must not change that request's outcome.
- Reserved control bits must read zero.
- The capability word must survive a write.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;

   // Outcome chosen for one request
   typedef enum logic [1:0] {
      LKD_PASS  = 2'd0,   // plain access, forwarded as is
      LKD_CACHE = 2'd1,   // atomic inside one cacheable line
      LKD_BUS   = 2'd2,   // atomic needing the system bus lock
      LKD_FAULT = 2'd3    // split atomic turned into a fault
   } lk_dec_t;

   // Bytes minus one for a size code, saturating at 2^max_log2
   function automatic int unsigned span_minus_one(input logic [2:0] code,
                                                  input int unsigned max_log2);
      int unsigned n;
      n = (int'(code) > int'(max_log2)) ? max_log2 : int'(code);
      return (32'd1 << n) - 32'd1;
   endfunction

endpackage

// File: rtl/alk_classifier.sv
module alk_classifier
   import atomic_lock_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LINE_LSB  = 6,
   parameter int unsigned MAX_LOG2  = 4,
   parameter bit          USE_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size_code,
   input  logic              locked,
   input  logic              cacheable,
   input  logic              detect_en,
   output logic              split,
   output lk_dec_t           dec
);

   localparam int unsigned LINE_IDX_W = ADDR_W + 1 - LINE_LSB;

   logic [ADDR_W:0]       span;
   logic [LINE_IDX_W-1:0] first_line;
   logic [LINE_IDX_W-1:0] last_line;

   always_comb begin
      span = (ADDR_W+1)'(span_minus_one(size_code, MAX_LOG2));
   end

   assign first_line = {1'b0, addr[ADDR_W-1:LINE_LSB]};

   generate
      if (USE_ADDER) begin : g_adder
         // Full-width sum: a carry out of the top bit marks a wrap as split
         logic [ADDR_W:0] last_byte;
         assign last_byte = {1'b0, addr} + span;
         assign last_line = last_byte[ADDR_W:LINE_LSB];
      end else begin : g_offset
         // Narrow sum on the in-line offset only; a carry means a crossing
         logic [LINE_LSB:0] off_sum;
         assign off_sum   = {1'b0, addr[LINE_LSB-1:0]} + span[LINE_LSB:0];
         assign last_line = first_line + LINE_IDX_W'(off_sum[LINE_LSB]);
      end
   endgenerate

   assign split = (last_line != first_line);

   always_comb begin
      if (!locked) begin
         dec = LKD_PASS;
      end else if (split) begin
         dec = detect_en ? LKD_FAULT : LKD_BUS;
      end else if (cacheable) begin
         dec = LKD_CACHE;
      end else begin
         dec = LKD_BUS;
      end
   end

endmodule

// File: rtl/alk_regfile.sv
module alk_regfile #(
   parameter int unsigned        REG_AW      = 12,
   parameter int unsigned        REG_DW      = 32,
   parameter logic [REG_AW-1:0]  CTRL_ADDR   = 12'h033,
   parameter int unsigned        CTRL_EN_BIT = 29,
   parameter logic [REG_AW-1:0]  CAP_ADDR    = 12'h0CF,
   parameter int unsigned        CAP_BIT     = 5,
   parameter bit                 RD_PIPE     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              detect_en
);

   localparam logic [REG_DW-1:0] EN_MASK  = REG_DW'(1) << CTRL_EN_BIT;
   localparam logic [REG_DW-1:0] CAP_WORD = REG_DW'(1) << CAP_BIT;

   logic              en_q;
   logic [REG_DW-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (reg_we && (reg_addr == CTRL_ADDR)) begin
         en_q <= |(reg_wdata & EN_MASK);
      end
   end

   always_comb begin
      if (reg_addr == CTRL_ADDR) begin
         rd_next = en_q ? EN_MASK : '0;
      end else if (reg_addr == CAP_ADDR) begin
         rd_next = CAP_WORD;
      end else begin
         rd_next = '0;
      end
   end

   generate
      if (RD_PIPE) begin : g_rd_flop
         logic [REG_DW-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_next;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_next;
      end
   endgenerate

   assign detect_en = en_q;

   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == CTRL_ADDR) |=> (detect_en == $past(reg_wdata[CTRL_EN_BIT]))); // R6

endmodule

// File: rtl/alk_lock_ctrl.sv
module alk_lock_ctrl
   import atomic_lock_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  lk_dec_t           dec,
   input  logic              lock_done,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              cache_lock,
   output logic              bus_lock,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr
);

   logic              bus_q;
   logic              fwd_q;
   logic              cl_q;
   logic              flt_q;
   logic [ADDR_W-1:0] faddr_q;
   logic [ADDR_W-1:0] fwaddr_q;
   logic              accept;

   assign req_ready = !bus_q;
   assign accept    = req_valid && !bus_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_q    <= 1'b0;
         fwd_q    <= 1'b0;
         cl_q     <= 1'b0;
         flt_q    <= 1'b0;
         faddr_q  <= '0;
         fwaddr_q <= '0;
      end else begin
         fwd_q <= 1'b0;
         cl_q  <= 1'b0;
         flt_q <= 1'b0;
         if (bus_q && lock_done) begin
            bus_q <= 1'b0;
         end
         if (accept) begin
            unique case (dec)
               LKD_PASS: begin
                  fwd_q    <= 1'b1;
                  fwaddr_q <= req_addr;
               end
               LKD_CACHE: begin
                  fwd_q    <= 1'b1;
                  cl_q     <= 1'b1;
                  fwaddr_q <= req_addr;
               end
               LKD_BUS: begin
                  fwd_q    <= 1'b1;
                  bus_q    <= 1'b1;
                  fwaddr_q <= req_addr;
               end
               LKD_FAULT: begin
                  flt_q   <= 1'b1;
                  faddr_q <= req_addr;
               end
               default: ;
            endcase
         end
      end
   end

   assign fwd_valid   = fwd_q;
   assign fwd_addr    = fwaddr_q;
   assign cache_lock  = cl_q;
   assign bus_lock    = bus_q;
   assign fault_valid = flt_q;
   assign fault_addr  = faddr_q;

   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_lock && !lock_done) |=> bus_lock); // R3

   AST_NO_ACCEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_lock |=> (!fwd_valid && !fault_valid && !cache_lock)); // R10

   AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (!fwd_valid && !bus_lock && !cache_lock)); // R5

   AST_CACHE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      cache_lock |-> (!bus_lock && fwd_valid)); // R1

endmodule

// File: rtl/atomic_lock_arb.sv
module atomic_lock_arb
   import atomic_lock_pkg::*;
#(
   parameter int unsigned        ADDR_W      = 32,
   parameter int unsigned        LINE_BYTES  = 64,
   parameter int unsigned        MAX_LOG2    = 4,
   parameter int unsigned        REG_AW      = 12,
   parameter int unsigned        REG_DW      = 32,
   parameter logic [REG_AW-1:0]  CTRL_ADDR   = 12'h033,
   parameter int unsigned        CTRL_EN_BIT = 29,
   parameter logic [REG_AW-1:0]  CAP_ADDR    = 12'h0CF,
   parameter int unsigned        CAP_BIT     = 5,
   parameter bit                 RD_PIPE     = 1'b0,
   parameter bit                 USE_ADDER   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size,
   input  logic              req_locked,
   input  logic              req_cacheable,
   output logic              fwd_valid,
   output logic [ADDR_W-1:0] fwd_addr,
   output logic              cache_lock,
   output logic              bus_lock,
   input  logic              lock_done,
   output logic              fault_valid,
   output logic [ADDR_W-1:0] fault_addr,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata
);

   localparam int unsigned LINE_LSB = $clog2(LINE_BYTES);

   generate
      if ((1 << LINE_LSB) != LINE_BYTES) begin : g_chk_line
         $error("LINE_BYTES must be a power of two");
      end
      if ((1 << MAX_LOG2) > LINE_BYTES) begin : g_chk_size
         $error("largest operand must fit inside one line");
      end
      if (LINE_LSB >= ADDR_W) begin : g_chk_addr
         $error("address too narrow for the line size");
      end
      if (CTRL_EN_BIT >= REG_DW || CAP_BIT >= REG_DW) begin : g_chk_bits
         $error("register bit position outside the data width");
      end
      if (CTRL_ADDR == CAP_ADDR) begin : g_chk_map
         $error("control and capability registers overlap");
      end
   endgenerate

   logic    detect_en;
   logic    split;
   lk_dec_t dec;

   alk_regfile #(
      .REG_AW(REG_AW), .REG_DW(REG_DW), .CTRL_ADDR(CTRL_ADDR),
      .CTRL_EN_BIT(CTRL_EN_BIT), .CAP_ADDR(CAP_ADDR), .CAP_BIT(CAP_BIT),
      .RD_PIPE(RD_PIPE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .detect_en(detect_en)
   );

   alk_classifier #(
      .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .MAX_LOG2(MAX_LOG2),
      .USE_ADDER(USE_ADDER)
   ) cls_i (
      .addr(req_addr), .size_code(req_size), .locked(req_locked),
      .cacheable(req_cacheable), .detect_en(detect_en), .split(split),
      .dec(dec)
   );

   alk_lock_ctrl #(
      .ADDR_W(ADDR_W)
   ) ctl_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .dec(dec), .lock_done(lock_done),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .cache_lock(cache_lock),
      .bus_lock(bus_lock), .fault_valid(fault_valid), .fault_addr(fault_addr)
   );

   AST_FAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> $past(detect_en)); // R5

   AST_UNCACHED_FIT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_locked && !req_cacheable && !split)
      |=> (bus_lock && !fault_valid)); // R4

endmodule

// File: tb/atomic_lock_arb_tb_top.sv
module atomic_lock_arb_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic        req_locked = 1'b0;
   logic        req_cacheable = 1'b0;
   logic        fwd_valid;
   logic [31:0] fwd_addr;
   logic        cache_lock;
   logic        bus_lock;
   logic        lock_done = 1'b0;
   logic        fault_valid;
   logic [31:0] fault_addr;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atomic_lock_arb dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_locked(req_locked),
      .req_cacheable(req_cacheable), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
      .cache_lock(cache_lock), .bus_lock(bus_lock), .lock_done(lock_done),
      .fault_valid(fault_valid), .fault_addr(fault_addr), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // fwd, cache_lock, bus_lock, fault as one 4-bit word
   task automatic check_out(input string req, input logic [3:0] exp);
      check(req, {60'd0, fwd_valid, cache_lock, bus_lock, fault_valid}, {60'd0, exp});
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // Offer one request for one edge; return at the next falling edge
   task automatic issue(input logic [31:0] a, input logic [2:0] s,
                        input logic lk, input logic ca);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = s;
      req_locked = lk; req_cacheable = ca;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic release_bus(input string req);
      @(negedge clk);
      lock_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      lock_done = 1'b0;
      check({req, " bus released"}, {63'd0, bus_lock}, 64'd0);
      check({req, " ready back"}, {63'd0, req_ready}, 64'd1);
   endtask

   function automatic bit is_split(input logic [31:0] a, input logic [2:0] s);
      logic [32:0] last;
      int n;
      n = (s > 3'd4) ? 4 : int'(s);
      last = {1'b0, a} + 33'((1 << n) - 1);
      return last[32:6] != {1'b0, a[31:6]};
   endfunction

   task automatic t_reset();
      logic [31:0] d;
      check("R6 reset ready", {63'd0, req_ready}, 64'd1);
      check_out("R6 reset outputs", 4'b0000);
      reg_read(12'h033, d);
      check("R6 reset enable", {32'd0, d}, 64'd0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      reg_write(12'h033, 32'hFFFF_FFFF);
      reg_read(12'h033, d);
      check("R7 only bit 29 kept", {32'd0, d}, 64'h2000_0000);
      reg_write(12'h033, 32'hDFFF_FFFF);
      reg_read(12'h033, d);
      check("R7 other bits ignored", {32'd0, d}, 64'd0);
      reg_write(12'h033, 32'h2000_0000);
      reg_read(12'h033, d);
      check("R6 enable readback", {32'd0, d}, 64'h2000_0000);
      reg_write(12'h033, 32'h0);
      reg_read(12'h0CF, d);
      check("R8 capability word", {32'd0, d}, 64'h20);
      reg_write(12'h0CF, 32'h0);
      reg_read(12'h0CF, d);
      check("R8 capability survives write", {32'd0, d}, 64'h20);
      reg_read(12'h034, d);
      check("R8 unmapped reads zero", {32'd0, d}, 64'd0);
   endtask

   task automatic t_cache_lock();
      issue(32'h0000_1008, 3'd3, 1'b1, 1'b1);
      check_out("R1 cache lock grant", 4'b1100);
      check("R1 forwarded address", {32'd0, fwd_addr}, 64'h1008);
      @(negedge clk);
      check_out("R1 pulses end", 4'b0000);
   endtask

   task automatic t_plain();
      reg_write(12'h033, 32'h2000_0000);
      issue(32'h0000_203D, 3'd3, 1'b0, 1'b1);
      check_out("R2 plain split store passes", 4'b1000);
      issue(32'h0000_2000, 3'd2, 1'b0, 1'b0);
      check_out("R2 plain uncached passes", 4'b1000);
      reg_write(12'h033, 32'h0);
   endtask

   task automatic t_bus_split();
      issue(32'h0000_303E, 3'd2, 1'b1, 1'b1);
      check_out("R3 bus lock on split", 4'b1010);
      check("R3 forwarded address", {32'd0, fwd_addr}, 64'h303E);
      check("R10 ready low while held", {63'd0, req_ready}, 64'd0);
      // Offer a request during the hold: it must be stalled
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h0000_4000; req_size = 3'd0;
      req_locked = 1'b1; req_cacheable = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check_out("R10 held request gives nothing", 4'b0010);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_out("R3 lock still held", 4'b0010);
      release_bus("R3");
   endtask

   task automatic t_uncached();
      reg_write(12'h033, 32'h2000_0000);
      issue(32'h0000_5010, 3'd3, 1'b1, 1'b0);
      check_out("R4 uncached fit takes bus lock", 4'b1010);
      release_bus("R4");
      reg_write(12'h033, 32'h0);
   endtask

   task automatic t_fault();
      // Write enable in the same cycle as a split request: old value applies
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 12'h033; reg_wdata = 32'h2000_0000;
      req_valid = 1'b1; req_addr = 32'h0000_607C; req_size = 3'd3;
      req_locked = 1'b1; req_cacheable = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0; req_valid = 1'b0;
      check_out("R6 enable sampled before write", 4'b1010);
      release_bus("R6");
      issue(32'h0000_707F, 3'd1, 1'b1, 1'b1);
      check_out("R5 fault on split", 4'b0001);
      check("R5 fault address", {32'd0, fault_addr}, 64'h707F);
      @(negedge clk);
      check_out("R5 fault is one pulse", 4'b0000);
      issue(32'h0000_703F, 3'd4, 1'b1, 1'b0);
      check_out("R5 uncached split also faults", 4'b0001);
   endtask

   task automatic t_sizes();
      logic [31:0] a;
      logic [2:0]  s;
      bit          sp;
      for (int i = 0; i < 11; i++) begin
         case (i)
            0:  begin a = 32'h3F; s = 3'd0; end
            1:  begin a = 32'h3F; s = 3'd1; end
            2:  begin a = 32'h3E; s = 3'd1; end
            3:  begin a = 32'h3C; s = 3'd2; end
            4:  begin a = 32'h3D; s = 3'd2; end
            5:  begin a = 32'h38; s = 3'd3; end
            6:  begin a = 32'h39; s = 3'd3; end
            7:  begin a = 32'h30; s = 3'd4; end
            8:  begin a = 32'h31; s = 3'd4; end
            9:  begin a = 32'h31; s = 3'd6; end
            default: begin a = 32'hFFFF_FFFF; s = 3'd1; end
         endcase
         sp = is_split(a, s);
         issue(a, s, 1'b1, 1'b1);
         check($sformatf("R9 size code %0d at %h", s, a),
               {60'd0, fwd_valid, cache_lock, bus_lock, fault_valid},
               sp ? 64'b0001 : 64'b1100);
      end
      reg_write(12'h033, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_cache_lock();
      t_plain();
      t_bus_split();
      t_uncached();
      t_fault();
      t_sizes();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule